// File: doc/BRIEF.md
# Clock Stop and Lock Monitor

This block watches the health of a clock generator from the digital side. It runs on a free-running monitor clock. It samples a primary reference, a secondary reference and a feedback clock through two-flop synchronisers and counts how many monitor cycles pass without a transition. If a watched clock stays quiet for longer than a programmable window, the block raises a sticky stopped flag for it. The reference window is twice as long as the feedback window, so the reference verdict takes about two feedback periods and the feedback verdict about one.

A behavioural stand-in for the phase detector supplies two synchronous flags, frequency match and phase match. The block combines these flags with clock activity into a registered feedback-lock output. It then ANDs that output with the lock indications of those deskew lanes that are enabled, which gives the overall lock. A stopped flag is released only after its clock toggles again and feedback lock has come back.

When overall lock is lost, a sticky reset-request output rises and stays high until the asynchronous reset is applied. The reference input choice is sampled once, right after reset is released. Changing it during operation therefore has no effect, so a switchover is done by holding the block in reset.

Top module: `clkmon_top`

## Requirements
- R1: With L = `stop_limit`, if the selected reference makes its last transition just before monitor edge k, `ref_stopped` is still 0 after edge k+2L+2 and is 1 after edge k+2L+3.
- R2: If `fb_clk` makes its last transition just before monitor edge k, `fb_stopped` is still 0 after edge k+L+2 and is 1 after edge k+L+3, and on that same edge `fb_locked` falls. `fb_stopped` is not affected by a stopped reference.
- R3: A stopped flag stays set while its clock is quiet or while `fb_locked` is 0. It clears only after the clock toggles again and `fb_locked` is 1.
- R4: `fb_locked` is a register that is 1 only when `freq_ok`, `phase_ok` and activity on both the selected reference and `fb_clk` were all present at the previous monitor edge. It falls on the first monitor edge after any of these is lost.
- R5: `locked` equals `fb_locked` AND, for every lane i, (`deskew_lock[i]` OR NOT `deskew_en[i]`). Bit i of each bus belongs to deskew lane i, and a disabled lane has no effect.
- R6: `in_sel` = 1 selects `ref_clk_pri` and `in_sel` = 0 selects `ref_clk_sec`. The value is captured on the first monitor edge after reset release, and later changes are ignored until the next reset.
- R7: `reset_req` rises on the monitor edge after `locked` falls. It stays 1 until `rst_n` is driven low.
- R8: Driving `rst_n` low clears `ref_stopped`, `fb_stopped`, `fb_locked`, `locked` and `reset_req` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_pri | input | 1 | Primary reference clock (asynchronous) |
| ref_clk_sec | input | 1 | Secondary reference clock (asynchronous) |
| fb_clk | input | 1 | Feedback clock (asynchronous) |
| in_sel | input | 1 | Reference select: 1 primary, 0 secondary |
| stop_limit | input | LIM_W | Feedback quiet window in monitor cycles (at least 2) |
| freq_ok | input | 1 | Frequency match flag from the detector stand-in |
| phase_ok | input | 1 | Phase match flag from the detector stand-in |
| deskew_en | input | NUM_DESKEW | Per-lane deskew enable |
| deskew_lock | input | NUM_DESKEW | Per-lane deskew lock |
| ref_stopped | output | 1 | Sticky reference-stopped flag |
| fb_stopped | output | 1 | Sticky feedback-stopped flag |
| fb_locked | output | 1 | Feedback lock |
| locked | output | 1 | Overall lock |
| reset_req | output | 1 | Sticky request to reset after lock loss |

## Verification
When a clock stops, its stopped flag rises and `fb_locked` falls on the same monitor edge, and `reset_req` follows one edge later. The bench stops the feedback clock at a recorded monitor cycle for several window lengths. It samples on both sides of the predicted edge and requires both outputs to change together. To check the release path, a clock is restarted while one lock flag is held low. The bench confirms the stopped flag stays set, then raises the lock flag and requires lock to return before the flag clears.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the clock stop and lock monitor.
// Assumes the monitored clocks are indexed in the order given by mon_src_e.
package clkmon_pkg;

    // Index of each monitored clock inside the synchroniser bank.
    typedef enum int {
        SRC_REF_PRI = 0,
        SRC_REF_SEC = 1,
        SRC_FB      = 2
    } mon_src_e;

    localparam int NUM_SRC     = 3;
    localparam int SYNC_STAGES = 2;

    // Activity verdicts for the two supervised paths.
    typedef struct packed {
        logic ref_idle;
        logic fb_idle;
    } idle_t;

endpackage

// File: rtl/clkmon_edge_sync.sv
`timescale 1ns/1ps
// Module: clkmon_edge_sync
// Brings one asynchronous clock into the monitor domain through a chain of
// STAGES flops. It then emits a one-cycle pulse for every transition seen at
// the end of the chain.
// Assumes the watched clock toggles slower than half the monitor rate.
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic raw_clk,
    output logic toggled
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the raw clock level through the synchroniser and history flop.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], raw_clk};
        end
    end

    // A transition is a difference between the last stage and its history.
    assign toggled = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/clkmon_gap_timer.sv
`timescale 1ns/1ps
// Module: clkmon_gap_timer
// Counts monitor cycles since the most recent edge pulse, saturating at its
// maximum. It reports idle once the count reaches the given window.
// Assumes the window is at least 2 so that a running clock never looks idle.
module clkmon_gap_timer #(
    parameter int CW = 9
) (
    input  logic          mon_clk,
    input  logic          rst_n,
    input  logic          edge_seen,
    input  logic [CW-1:0] window,
    output logic          idle
);

    localparam logic [CW-1:0] GAP_MAX = '1;

    logic [CW-1:0] gap_q;

    // Restart the gap on an edge, otherwise count up to saturation.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (edge_seen) begin
            gap_q <= '0;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Compare the running gap with the quiet window.
    assign idle = (gap_q >= window);

endmodule

// File: rtl/clkmon_lock_combine.sv
`timescale 1ns/1ps
// Module: clkmon_lock_combine
// Forms the overall lock from the feedback lock and the deskew lanes. A lane
// that is not enabled is treated as satisfied.
// Assumes lane enables are static or change only in step with the monitor clock.
module clkmon_lock_combine #(
    parameter int NLANE = 2
) (
    input  logic             fb_locked,
    input  logic [NLANE-1:0] lane_en,
    input  logic [NLANE-1:0] lane_lock,
    output logic             all_locked
);

    logic [NLANE-1:0] lane_ok;

    // One satisfaction term per deskew lane.
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lane_ok[i] = lane_lock[i] | ~lane_en[i];
    end

    // The overall lock needs feedback lock and every lane satisfied.
    assign all_locked = fb_locked & (&lane_ok);

endmodule

// File: rtl/clkmon_flag_ctrl.sv
`timescale 1ns/1ps
// Module: clkmon_flag_ctrl
// Holds the sticky stopped flags, the registered feedback lock, the reset
// request and the reference select, which is captured once after reset.
// Flags only start updating after the first monitor edge following reset.
// Assumes the idle verdicts and the detector flags are in the monitor domain.
module clkmon_flag_ctrl
    import clkmon_pkg::*;
(
    input  logic  mon_clk,
    input  logic  rst_n,
    input  logic  in_sel,
    input  idle_t idle,
    input  logic  freq_ok,
    input  logic  phase_ok,
    input  logic  all_locked,
    output logic  sel_pri,
    output logic  ref_stopped,
    output logic  fb_stopped,
    output logic  fb_locked,
    output logic  reset_req
);

    logic armed_q;
    logic locked_d;

    // Arm the flag logic on the first monitor edge after reset release.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // Capture the reference choice once, while not yet armed.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n)        sel_pri <= 1'b1;
        else if (!armed_q) sel_pri <= in_sel;
    end

    // Feedback lock needs both detector flags and both clocks active.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) fb_locked <= 1'b0;
        else        fb_locked <= armed_q & freq_ok & phase_ok
                                 & ~idle.ref_idle & ~idle.fb_idle;
    end

    // Reference-stopped flag: set on idle, cleared after activity and relock.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_stopped <= 1'b0;
        end else if (armed_q && idle.ref_idle) begin
            ref_stopped <= 1'b1;
        end else if (ref_stopped && !idle.ref_idle && fb_locked) begin
            ref_stopped <= 1'b0;
        end
    end

    // Feedback-stopped flag: same release rule as the reference flag.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_stopped <= 1'b0;
        end else if (armed_q && idle.fb_idle) begin
            fb_stopped <= 1'b1;
        end else if (fb_stopped && !idle.fb_idle && fb_locked) begin
            fb_stopped <= 1'b0;
        end
    end

    // Delay the overall lock to spot a falling edge.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) locked_d <= 1'b0;
        else        locked_d <= all_locked;
    end

    // Sticky reset request once the overall lock has fallen.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n)                                reset_req <= 1'b0;
        else if (armed_q && locked_d && !all_locked) reset_req <= 1'b1;
    end

endmodule

// File: rtl/clkmon_top.sv
`timescale 1ns/1ps
// Module: clkmon_top
// Clock stop and lock monitor. It synchronises the two reference clocks and
// the feedback clock, times quiet gaps, keeps sticky stopped flags, and forms
// the feedback and overall lock outputs plus a sticky reset request.
// Assumes stop_limit >= 2 and that the watched clocks run below a quarter of
// the monitor clock rate.
module clkmon_top #(
    parameter int LIM_W      = 8,
    parameter int NUM_DESKEW = 2
) (
    input  logic                  mon_clk,
    input  logic                  rst_n,
    input  logic                  ref_clk_pri,
    input  logic                  ref_clk_sec,
    input  logic                  fb_clk,
    input  logic                  in_sel,
    input  logic [LIM_W-1:0]      stop_limit,
    input  logic                  freq_ok,
    input  logic                  phase_ok,
    input  logic [NUM_DESKEW-1:0] deskew_en,
    input  logic [NUM_DESKEW-1:0] deskew_lock,
    output logic                  ref_stopped,
    output logic                  fb_stopped,
    output logic                  fb_locked,
    output logic                  locked,
    output logic                  reset_req
);
    import clkmon_pkg::*;

    localparam int GAP_W = LIM_W + 1;

    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] tog_vec;
    logic               sel_pri;
    logic               ref_edge;
    logic [GAP_W-1:0]   ref_window;
    logic [GAP_W-1:0]   fb_window;
    idle_t              idle;

    assign raw_vec[SRC_REF_PRI] = ref_clk_pri;
    assign raw_vec[SRC_REF_SEC] = ref_clk_sec;
    assign raw_vec[SRC_FB]      = fb_clk;

    // One synchroniser and edge detector per watched clock.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
        clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .mon_clk (mon_clk),
            .rst_n   (rst_n),
            .raw_clk (raw_vec[i]),
            .toggled (tog_vec[i])
        );
    end

    // Route the selected reference and derive both quiet windows.
    assign ref_edge   = sel_pri ? tog_vec[SRC_REF_PRI] : tog_vec[SRC_REF_SEC];
    assign ref_window = {stop_limit, 1'b0};
    assign fb_window  = {1'b0, stop_limit};

    clkmon_gap_timer #(.CW(GAP_W)) u_ref_gap (
        .mon_clk   (mon_clk),
        .rst_n     (rst_n),
        .edge_seen (ref_edge),
        .window    (ref_window),
        .idle      (idle.ref_idle)
    );

    clkmon_gap_timer #(.CW(GAP_W)) u_fb_gap (
        .mon_clk   (mon_clk),
        .rst_n     (rst_n),
        .edge_seen (tog_vec[SRC_FB]),
        .window    (fb_window),
        .idle      (idle.fb_idle)
    );

    clkmon_flag_ctrl u_flags (
        .mon_clk     (mon_clk),
        .rst_n       (rst_n),
        .in_sel      (in_sel),
        .idle        (idle),
        .freq_ok     (freq_ok),
        .phase_ok    (phase_ok),
        .all_locked  (locked),
        .sel_pri     (sel_pri),
        .ref_stopped (ref_stopped),
        .fb_stopped  (fb_stopped),
        .fb_locked   (fb_locked),
        .reset_req   (reset_req)
    );

    clkmon_lock_combine #(.NLANE(NUM_DESKEW)) u_lock (
        .fb_locked  (fb_locked),
        .lane_en    (deskew_en),
        .lane_lock  (deskew_lock),
        .all_locked (locked)
    );

endmodule

// File: rtl/clkmon_checker.sv
`timescale 1ns/1ps
// Module: clkmon_checker
// Temporal properties of the monitor's outputs. It is attached to the top
// module by the bind statement at the end of this file.
module clkmon_checker #(
    parameter int ND = 2
) (
    input logic          mon_clk,
    input logic          rst_n,
    input logic          freq_ok,
    input logic          phase_ok,
    input logic [ND-1:0] deskew_en,
    input logic [ND-1:0] deskew_lock,
    input logic          ref_stopped,
    input logic          fb_stopped,
    input logic          fb_locked,
    input logic          locked,
    input logic          reset_req
);

    assert_ref_hold_R3: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (ref_stopped && !fb_locked) |=> ref_stopped);

    assert_fb_hold_R3: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (fb_stopped && !fb_locked) |=> fb_stopped);

    assert_freq_drop_R4: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !freq_ok |=> !fb_locked);

    assert_phase_drop_R4: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !phase_ok |=> !fb_locked);

    assert_lock_needs_fb_R5: assert property (@(posedge mon_clk) disable iff (!rst_n)
        locked |-> fb_locked);

    for (genvar i = 0; i < ND; i++) begin : g_lane_chk
        assert_lane_lock_R5: assert property (@(posedge mon_clk) disable iff (!rst_n)
            (locked && deskew_en[i]) |-> deskew_lock[i]);
    end

    assert_req_on_drop_R7: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $fell(locked) |=> reset_req);

    assert_req_sticky_R7: assert property (@(posedge mon_clk) disable iff (!rst_n)
        reset_req |=> reset_req);

endmodule

bind clkmon_top clkmon_checker #(.ND(NUM_DESKEW)) u_checker (
    .mon_clk     (mon_clk),
    .rst_n       (rst_n),
    .freq_ok     (freq_ok),
    .phase_ok    (phase_ok),
    .deskew_en   (deskew_en),
    .deskew_lock (deskew_lock),
    .ref_stopped (ref_stopped),
    .fb_stopped  (fb_stopped),
    .fb_locked   (fb_locked),
    .locked      (locked),
    .reset_req   (reset_req)
);

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps window lengths and deskew combinations and predicts the
// exact edge of each stopped verdict from the recorded last transition.
module clkmon_top_tb_top;

    localparam int LIM_W = 8;
    localparam int ND    = 2;

    logic          mon_clk = 1'b0;
    logic          rst_n;
    logic          ref_a = 1'b0;
    logic          ref_b = 1'b0;
    logic          fbc   = 1'b0;
    logic          in_sel;
    logic [LIM_W-1:0] stop_limit;
    logic          freq_ok, phase_ok;
    logic [ND-1:0] deskew_en, deskew_lock;
    logic          ref_stopped, fb_stopped, fb_locked, locked, reset_req;

    int  cyc = 0;
    bit  run_a, run_b, run_fb;
    int  last_a = 0, last_b = 0, last_fb = 0;
    int  n_checks = 0, n_fail = 0;
    bit  done = 0;

    always #2.5 mon_clk = ~mon_clk;

    always @(posedge mon_clk) cyc <= cyc + 1;

    // Watched clocks toggle on falling monitor edges every second cycle.
    always @(negedge mon_clk) begin
        if (cyc % 2 == 0) begin
            if (run_a)  begin ref_a <= ~ref_a; last_a  <= cyc; end
            if (run_b)  begin ref_b <= ~ref_b; last_b  <= cyc; end
            if (run_fb) begin fbc   <= ~fbc;   last_fb <= cyc; end
        end
    end

    clkmon_top #(.LIM_W(LIM_W), .NUM_DESKEW(ND)) dut_i (
        .mon_clk     (mon_clk),
        .rst_n       (rst_n),
        .ref_clk_pri (ref_a),
        .ref_clk_sec (ref_b),
        .fb_clk      (fbc),
        .in_sel      (in_sel),
        .stop_limit  (stop_limit),
        .freq_ok     (freq_ok),
        .phase_ok    (phase_ok),
        .deskew_en   (deskew_en),
        .deskew_lock (deskew_lock),
        .ref_stopped (ref_stopped),
        .fb_stopped  (fb_stopped),
        .fb_locked   (fb_locked),
        .locked      (locked),
        .reset_req   (reset_req)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Return at the falling edge that follows monitor edge number t.
    task automatic wait_until(input int t);
        while (cyc < t) begin
            @(posedge mon_clk);
            #1;
        end
        @(negedge mon_clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge mon_clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int tgt;
        rst_n = 1'b0; in_sel = 1'b1; stop_limit = 8'd4;
        freq_ok = 1'b1; phase_ok = 1'b1; deskew_en = '0; deskew_lock = '0;
        run_a = 1; run_b = 1; run_fb = 1;
        idle_cycles(3);
        // R8: outputs are cleared while reset is held
        chk("R8", "ref_stopped in reset", ref_stopped, 1'b0);
        chk("R8", "fb_stopped in reset", fb_stopped, 1'b0);
        chk("R8", "fb_locked in reset", fb_locked, 1'b0);
        chk("R8", "locked in reset", locked, 1'b0);
        chk("R8", "reset_req in reset", reset_req, 1'b0);
        rst_n = 1'b1;
        idle_cycles(12);
        chk("R4", "fb_locked after start", fb_locked, 1'b1);
        chk("R5", "locked, lanes disabled", locked, 1'b1);
        chk("R3", "no stop flags at start", ref_stopped | fb_stopped, 1'b0);
        chk("R7", "no reset_req at start", reset_req, 1'b0);

        // R5: exhaustive lane sweep with feedback lock high, then low
        for (int ph = 1; ph >= 0; ph--) begin
            phase_ok = ph[0];
            idle_cycles(2);
            if (ph == 0) chk("R4", "fb_locked after phase loss", fb_locked, 1'b0);
            for (int v = 0; v < 16; v++) begin
                @(negedge mon_clk);
                deskew_en   = v[1:0];
                deskew_lock = v[3:2];
                #1;
                chk("R5", $sformatf("locked en=%0d lk=%0d fb=%0d", v[1:0], v[3:2], ph),
                    locked, ph[0] & (&(v[3:2] | ~v[1:0])));
            end
        end
        deskew_en = '0;
        chk("R7", "reset_req after lock loss", reset_req, 1'b1);
        phase_ok = 1'b1;
        idle_cycles(4);
        chk("R4", "fb_locked back", fb_locked, 1'b1);
        chk("R7", "reset_req still set", reset_req, 1'b1);

        // R4: one-edge drop on frequency loss
        @(negedge mon_clk); freq_ok = 1'b0;
        @(negedge mon_clk);
        chk("R4", "fb_locked after freq loss", fb_locked, 1'b0);
        freq_ok = 1'b1;
        idle_cycles(3);

        // R2/R3: feedback stop timing and release over several windows
        for (int k = 0; k < 3; k++) begin
            int lim;
            lim = (k == 0) ? 3 : (k == 1) ? 4 : 6;
            stop_limit = lim[LIM_W-1:0];
            idle_cycles(6);
            @(posedge mon_clk); #1; run_fb = 0;
            tgt = last_fb + 3 + lim;
            wait_until(tgt);
            chk("R2", $sformatf("fb_stopped before, L=%0d", lim), fb_stopped, 1'b0);
            chk("R4", $sformatf("fb_locked before, L=%0d", lim), fb_locked, 1'b1);
            wait_until(tgt + 1);
            chk("R2", $sformatf("fb_stopped on edge, L=%0d", lim), fb_stopped, 1'b1);
            chk("R4", $sformatf("fb_locked on edge, L=%0d", lim), fb_locked, 1'b0);
            freq_ok = 1'b0;
            run_fb = 1;
            idle_cycles(20);
            chk("R3", "fb_stopped held without lock", fb_stopped, 1'b1);
            freq_ok = 1'b1;
            idle_cycles(12);
            chk("R3", "fb_stopped released after relock", fb_stopped, 1'b0);
            chk("R4", "fb_locked after restart", fb_locked, 1'b1);
        end

        // R1: reference stop timing, feedback verdict unaffected
        stop_limit = 8'd4;
        idle_cycles(6);
        @(posedge mon_clk); #1; run_a = 0;
        tgt = last_a + 3 + 8;
        wait_until(tgt);
        chk("R1", "ref_stopped before", ref_stopped, 1'b0);
        wait_until(tgt + 1);
        chk("R1", "ref_stopped on edge", ref_stopped, 1'b1);
        chk("R4", "fb_locked on ref stop", fb_locked, 1'b0);
        chk("R2", "fb_stopped not raised by ref", fb_stopped, 1'b0);
        phase_ok = 1'b0;
        run_a = 1;
        idle_cycles(20);
        chk("R3", "ref_stopped held without lock", ref_stopped, 1'b1);
        phase_ok = 1'b1;
        idle_cycles(12);
        chk("R3", "ref_stopped released after relock", ref_stopped, 1'b0);

        // R8/R7: asynchronous reset clears flags mid-cycle
        @(posedge mon_clk); #1;
        rst_n = 1'b0;
        #0.5;
        chk("R8", "reset_req cleared async", reset_req, 1'b0);
        chk("R8", "fb_locked cleared async", fb_locked, 1'b0);
        chk("R8", "locked cleared async", locked, 1'b0);

        // R6: secondary selected in reset, later select change ignored
        in_sel = 1'b0; run_a = 0; run_b = 1;
        idle_cycles(2);
        rst_n = 1'b1;
        idle_cycles(30);
        chk("R6", "secondary watched, no stop", ref_stopped, 1'b0);
        chk("R6", "lock on secondary", fb_locked, 1'b1);
        in_sel = 1'b1;
        idle_cycles(30);
        chk("R6", "run-time select ignored", ref_stopped, 1'b0);
        run_b = 0;
        idle_cycles(2 * 4 + 8);
        chk("R6", "secondary stop detected", ref_stopped, 1'b1);
        chk("R7", "reset_req after ref loss", reset_req, 1'b1);

        finish_run();
    end

endmodule